// File: doc/BRIEF.md
# ATM Cell Upstream Loopback Unit

This unit sits between a line-side framer and a cell-level transmit path. Every cell that the framer delivers is passed on to the receive port toward the ATM layer. When looping is enabled, a copy of a selected cell is also stored in a small cell buffer and later sent out on the line transmit path. Stored cells take precedence over new cells from the ATM layer at cell boundaries. While any looped cell is held, the unit lowers its transmit cell-available flag so that the ATM layer stops offering new cells.

Two port modes exist. In whole-port mode every received cell is looped, and the receive side always sees it. In adaptation-layer mode, an optional filter on the five lowest VCI bits picks a single channel. A hide control then decides whether looped cells are withheld from the receive side. The forward path has a fixed delay of four clock cycles. This gives the unit time to read the VCI bits before the first byte of the cell leaves, so a cell can be hidden as a whole. All configuration inputs are static while cells flow.

Top module: `atm_upstream_loop`

## Requirements
- R1: A cell is 53 bytes on an 8-bit bus, presented in consecutive valid cycles with the start-of-cell strobe on byte 0. The five VCI bits compared by the filter are {byte 2 bit 0, byte 3 bits 7:4}, with byte numbering starting at 0.
- R2: With `cfg_loop_en` = 0 no cell is looped. The line transmit output carries only ATM-layer cells, and `atm_tx_cav` stays 1.
- R3: Every cell that is not hidden appears on the receive output unchanged, with its start strobe exactly 4 clock cycles after it entered.
- R4: With `cfg_aal_mode` = 0 every received cell is looped and also shown on the receive output, whatever `cfg_filt_en`, `cfg_vci_match` and `cfg_hide` hold.
- R5: With `cfg_aal_mode` = 1 and `cfg_filt_en` = 0, every received cell is looped.
- R6: With `cfg_aal_mode` = 1 and `cfg_filt_en` = 1, only cells whose five VCI bits (R1) equal `cfg_vci_match` are looped.
- R7: With `cfg_aal_mode` = 1 and `cfg_hide` = 1, looped cells do not appear on the receive output. Cells that are not looped still appear.
- R8: The buffer holds at most 4 cells. A cell selected while 4 cells are held is not looped and is still shown on the receive output, and `loop_ovf` rises and stays at 1 until reset.
- R9: `atm_tx_cav` goes to 0 once a cell is selected for looping, which is decided at byte 3. It returns to 1 only after the last held cell has been fully sent.
- R10: Looped cells go out whole, in consecutive cycles and in order of arrival. An ATM-layer cell already started, including one that stalls, completes before a looped cell begins.
- R11: After reset both output valids are 0, `atm_tx_cav` is 1 and `loop_ovf` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_loop_en | input | 1 | Per-port loop enable |
| cfg_aal_mode | input | 1 | 1: adaptation-layer mode, 0: whole-port mode |
| cfg_filt_en | input | 1 | Enables the single-channel VCI filter |
| cfg_vci_match | input | 5 | VCI value that the filter compares against |
| cfg_hide | input | 1 | Hides looped cells from the receive side (adaptation-layer mode only) |
| line_rx_valid | input | 1 | Byte valid from the framer |
| line_rx_soc | input | 1 | Start of cell from the framer |
| line_rx_data | input | 8 | Byte from the framer |
| rcv_valid | output | 1 | Byte valid toward the receive port |
| rcv_soc | output | 1 | Start of cell toward the receive port |
| rcv_data | output | 8 | Byte toward the receive port |
| atm_tx_valid | input | 1 | Byte valid from the ATM layer |
| atm_tx_soc | input | 1 | Start of cell from the ATM layer |
| atm_tx_data | input | 8 | Byte from the ATM layer |
| atm_tx_cav | output | 1 | Transmit cell-available flag toward the ATM layer |
| line_tx_valid | output | 1 | Byte valid toward the line transmitter |
| line_tx_soc | output | 1 | Start of cell toward the line transmitter |
| line_tx_data | output | 8 | Byte toward the line transmitter |
| loop_ovf | output | 1 | Sticky flag: a selected cell was dropped from the loop |

## Verification
The assertions take for granted that framer cells arrive in 53 consecutive valid cycles, so the byte held one stage earlier in the delay line is the previous header byte. They also assume that the ATM layer starts a cell only while `atm_tx_cav` is 1, and that configuration changes only while no cell is in flight. The stimulus drives framer cells as unbroken bursts, including back-to-back runs. Its ATM-layer driver waits for the flag before each start of cell and stalls only in the middle of a cell. Configuration is written only after the unit has gone quiet.

// File: rtl/ulp_pkg.sv
package ulp_pkg;
    localparam int BYTE_W    = 8;
    localparam int VCI_SEL_W = 5;
    // header byte index that carries the VCI low nibble; the decision is taken there
    localparam int DECIDE_AT = 3;

    typedef struct packed {
        logic              valid;
        logic              soc;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_ATM  = 2'd1,
        TX_LOOP = 2'd2
    } tx_state_e;
endpackage

// File: rtl/ulp_rx_tap.sv
module ulp_rx_tap
    import ulp_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_loop_en,
    input  logic                 cfg_aal_mode,
    input  logic                 cfg_filt_en,
    input  logic [VCI_SEL_W-1:0] cfg_vci_match,
    input  logic                 cfg_hide,
    input  logic                 in_valid,
    input  logic                 in_soc,
    input  logic [BYTE_W-1:0]    in_data,
    input  logic                 room,
    output logic                 reserve,
    output logic                 out_valid,
    output logic                 out_soc,
    output logic [BYTE_W-1:0]    out_data,
    output logic                 wr_valid,
    output logic                 wr_soc,
    output logic [BYTE_W-1:0]    wr_data,
    output logic                 ovf
);
    localparam int PIPE  = DECIDE_AT + 1;
    localparam int IDX_W = $clog2(CELL_BYTES + 1);

    typedef struct packed {
        beat_t [PIPE-1:0] pipe;
        logic [IDX_W-1:0] idx;
        logic             loop;
        logic             hide;
        logic             ovf;
    } tap_st_t;

    tap_st_t st_q, st_d;
    logic [IDX_W-1:0]     idx_now;
    logic                 decide;
    logic                 want;
    logic [VCI_SEL_W-1:0] vci_low;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = {in_valid, in_soc, in_data};
        for (int k = 1; k < PIPE; k++) begin
            st_d.pipe[k] = st_q.pipe[k-1];
        end
        idx_now = in_soc ? '0 : st_q.idx;
        if (in_valid) begin
            st_d.idx = IDX_W'(idx_now + 1'b1);
        end
        decide  = in_valid && (idx_now == IDX_W'(DECIDE_AT));
        vci_low = {st_q.pipe[0].data[0], in_data[7:4]};
        want    = cfg_loop_en &&
                  (!cfg_aal_mode || !cfg_filt_en || (vci_low == cfg_vci_match));
        reserve = decide && want && room;
        if (decide) begin
            st_d.loop = want && room;
            st_d.hide = want && room && cfg_aal_mode && cfg_hide;
            if (want && !room) begin
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.pipe[PIPE-1].valid && !st_q.hide;
    assign out_soc   = st_q.pipe[PIPE-1].soc;
    assign out_data  = st_q.pipe[PIPE-1].data;
    assign wr_valid  = st_q.pipe[PIPE-1].valid && st_q.loop;
    assign wr_soc    = st_q.pipe[PIPE-1].soc;
    assign wr_data   = st_q.pipe[PIPE-1].data;
    assign ovf       = st_q.ovf;

    // whole-port mode never hides a cell
    assert_atm_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_aal_mode && st_q.pipe[PIPE-1].valid) |-> out_valid);

    // nothing reaches the buffer while looping is off
    assert_disabled_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_loop_en |-> !wr_valid);

    // once the sticky flag is up it stays up
    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |=> st_q.ovf);
endmodule

// File: rtl/ulp_cell_buf.sv
module ulp_cell_buf
    import ulp_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reserve,
    input  logic              wr_valid,
    input  logic              wr_soc,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_pop,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_last,
    output logic              cell_ready,
    output logic              room,
    output logic              busy
);
    localparam int MEM_N  = DEPTH * CELL_BYTES;
    localparam int ADDR_W = $clog2(MEM_N);
    localparam int BYTE_I = $clog2(CELL_BYTES);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0]  wr_cell;
        logic [BYTE_I-1:0] wr_byte;
        logic [PTR_W-1:0]  rd_cell;
        logic [BYTE_I-1:0] rd_byte;
        logic [CNT_W-1:0]  resv;
        logic [CNT_W-1:0]  ready;
    } buf_st_t;

    buf_st_t st_q, st_d;
    logic [BYTE_W-1:0] mem [MEM_N];
    logic [BYTE_I-1:0] wb_now;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_done;
    logic              rd_free;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
    endfunction

    always_comb begin
        st_d    = st_q;
        wb_now  = wr_soc ? '0 : st_q.wr_byte;
        wr_addr = ADDR_W'(st_q.wr_cell) * ADDR_W'(CELL_BYTES) + ADDR_W'(wb_now);
        rd_addr = ADDR_W'(st_q.rd_cell) * ADDR_W'(CELL_BYTES) + ADDR_W'(st_q.rd_byte);
        rd_last = (st_q.rd_byte == BYTE_I'(CELL_BYTES - 1));
        wr_done = wr_valid && (wb_now == BYTE_I'(CELL_BYTES - 1));
        rd_free = rd_pop && rd_last;
        if (wr_valid) begin
            st_d.wr_byte = BYTE_I'(wb_now + 1'b1);
            if (wr_done) begin
                st_d.wr_cell = bump(st_q.wr_cell);
            end
        end
        if (rd_pop) begin
            if (rd_last) begin
                st_d.rd_byte = '0;
                st_d.rd_cell = bump(st_q.rd_cell);
            end else begin
                st_d.rd_byte = BYTE_I'(st_q.rd_byte + 1'b1);
            end
        end
        st_d.resv  = CNT_W'(st_q.resv + CNT_W'(reserve) - CNT_W'(rd_free));
        st_d.ready = CNT_W'(st_q.ready + CNT_W'(wr_done) - CNT_W'(rd_free));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_valid) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data    = mem[rd_addr];
    assign cell_ready = (st_q.ready != '0);
    assign room       = (st_q.resv < CNT_W'(DEPTH));
    assign busy       = (st_q.resv != '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.resv <= CNT_W'(DEPTH));

    assert_ready_within_resv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ready <= st_q.resv);

    // the transmit side only reads a cell that has been stored completely
    assert_pop_has_cell_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pop |-> cell_ready);
endmodule

// File: rtl/ulp_tx_mux.sv
module ulp_tx_mux
    import ulp_pkg::*;
#(
    parameter int CELL_BYTES = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              atm_valid,
    input  logic              atm_soc,
    input  logic [BYTE_W-1:0] atm_data,
    input  logic              cell_ready,
    input  logic [BYTE_W-1:0] rd_data,
    input  logic              rd_last,
    output logic              rd_pop,
    output logic              tx_valid,
    output logic              tx_soc,
    output logic [BYTE_W-1:0] tx_data
);
    localparam int CNT_W = $clog2(CELL_BYTES);

    typedef struct packed {
        tx_state_e        state;
        logic [CNT_W-1:0] cnt;
        beat_t            tx;
    } mux_st_t;

    mux_st_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.tx = '0;
        rd_pop  = 1'b0;
        unique case (st_q.state)
            TX_IDLE: begin
                if (cell_ready) begin
                    rd_pop     = 1'b1;
                    st_d.tx    = {1'b1, 1'b1, rd_data};
                    st_d.state = TX_LOOP;
                end else if (atm_valid && atm_soc) begin
                    st_d.tx    = {1'b1, 1'b1, atm_data};
                    st_d.cnt   = CNT_W'(1);
                    st_d.state = TX_ATM;
                end
            end
            TX_ATM: begin
                if (atm_valid) begin
                    st_d.tx  = {1'b1, 1'b0, atm_data};
                    st_d.cnt = CNT_W'(st_q.cnt + 1'b1);
                    if (st_q.cnt == CNT_W'(CELL_BYTES - 1)) begin
                        st_d.state = TX_IDLE;
                    end
                end
            end
            TX_LOOP: begin
                rd_pop  = 1'b1;
                st_d.tx = {1'b1, 1'b0, rd_data};
                if (rd_last) begin
                    st_d.state = TX_IDLE;
                end
            end
            default: st_d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: TX_IDLE, cnt: '0, tx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.tx.valid;
    assign tx_soc   = st_q.tx.soc;
    assign tx_data  = st_q.tx.data;

    // a looped cell is under way only while the buffer reports a stored cell
    assert_loop_backed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_LOOP) |-> cell_ready);

    // input assumption: the ATM layer obeys the lowered cell-available flag
    assert_atm_holds_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_LOOP) |-> !(atm_valid && atm_soc));

    // a looped byte is followed by another output byte in the next cycle until the end
    assert_loop_contiguous_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == TX_LOOP && !rd_last) |=> (tx_valid && !tx_soc));
endmodule

// File: rtl/atm_upstream_loop.sv
module atm_upstream_loop
    import ulp_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int DEPTH      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_loop_en,
    input  logic                 cfg_aal_mode,
    input  logic                 cfg_filt_en,
    input  logic [VCI_SEL_W-1:0] cfg_vci_match,
    input  logic                 cfg_hide,
    input  logic                 line_rx_valid,
    input  logic                 line_rx_soc,
    input  logic [BYTE_W-1:0]    line_rx_data,
    output logic                 rcv_valid,
    output logic                 rcv_soc,
    output logic [BYTE_W-1:0]    rcv_data,
    input  logic                 atm_tx_valid,
    input  logic                 atm_tx_soc,
    input  logic [BYTE_W-1:0]    atm_tx_data,
    output logic                 atm_tx_cav,
    output logic                 line_tx_valid,
    output logic                 line_tx_soc,
    output logic [BYTE_W-1:0]    line_tx_data,
    output logic                 loop_ovf
);
    logic              reserve;
    logic              room;
    logic              busy;
    logic              wr_valid;
    logic              wr_soc;
    logic [BYTE_W-1:0] wr_data;
    logic              rd_pop;
    logic [BYTE_W-1:0] rd_data;
    logic              rd_last;
    logic              cell_ready;

    ulp_rx_tap #(.CELL_BYTES(CELL_BYTES)) tap_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_loop_en   (cfg_loop_en),
        .cfg_aal_mode  (cfg_aal_mode),
        .cfg_filt_en   (cfg_filt_en),
        .cfg_vci_match (cfg_vci_match),
        .cfg_hide      (cfg_hide),
        .in_valid      (line_rx_valid),
        .in_soc        (line_rx_soc),
        .in_data       (line_rx_data),
        .room          (room),
        .reserve       (reserve),
        .out_valid     (rcv_valid),
        .out_soc       (rcv_soc),
        .out_data      (rcv_data),
        .wr_valid      (wr_valid),
        .wr_soc        (wr_soc),
        .wr_data       (wr_data),
        .ovf           (loop_ovf)
    );

    ulp_cell_buf #(.CELL_BYTES(CELL_BYTES), .DEPTH(DEPTH)) buf_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reserve    (reserve),
        .wr_valid   (wr_valid),
        .wr_soc     (wr_soc),
        .wr_data    (wr_data),
        .rd_pop     (rd_pop),
        .rd_data    (rd_data),
        .rd_last    (rd_last),
        .cell_ready (cell_ready),
        .room       (room),
        .busy       (busy)
    );

    ulp_tx_mux #(.CELL_BYTES(CELL_BYTES)) mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .atm_valid  (atm_tx_valid),
        .atm_soc    (atm_tx_soc),
        .atm_data   (atm_tx_data),
        .cell_ready (cell_ready),
        .rd_data    (rd_data),
        .rd_last    (rd_last),
        .rd_pop     (rd_pop),
        .tx_valid   (line_tx_valid),
        .tx_soc     (line_tx_soc),
        .tx_data    (line_tx_data)
    );

    assign atm_tx_cav = !busy;

    // a stored cell never coexists with a raised cell-available flag
    assert_cav_low_when_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cell_ready |-> !atm_tx_cav);
endmodule

// File: tb/atm_upstream_loop_tb_top.sv
module atm_upstream_loop_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_loop_en = 1'b0, cfg_aal_mode = 1'b0, cfg_filt_en = 1'b0, cfg_hide = 1'b0;
    logic [4:0] cfg_vci_match = '0;
    logic       line_rx_valid = 1'b0, line_rx_soc = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic       atm_tx_valid = 1'b0, atm_tx_soc = 1'b0;
    logic [7:0] atm_tx_data = '0;
    logic       rcv_valid, rcv_soc, atm_tx_cav, line_tx_valid, line_tx_soc, loop_ovf;
    logic [7:0] rcv_data, line_tx_data;

    always #10 clk = ~clk;

    atm_upstream_loop dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_loop_en(cfg_loop_en), .cfg_aal_mode(cfg_aal_mode), .cfg_filt_en(cfg_filt_en),
        .cfg_vci_match(cfg_vci_match), .cfg_hide(cfg_hide),
        .line_rx_valid(line_rx_valid), .line_rx_soc(line_rx_soc), .line_rx_data(line_rx_data),
        .rcv_valid(rcv_valid), .rcv_soc(rcv_soc), .rcv_data(rcv_data),
        .atm_tx_valid(atm_tx_valid), .atm_tx_soc(atm_tx_soc), .atm_tx_data(atm_tx_data),
        .atm_tx_cav(atm_tx_cav),
        .line_tx_valid(line_tx_valid), .line_tx_soc(line_tx_soc), .line_tx_data(line_tx_data),
        .loop_ovf(loop_ovf)
    );

    int total = 0, bad = 0, cyc = 0;
    bit done = 1'b0;
    logic [7:0] rx_tags [16];
    logic [7:0] tx_tags [16];
    int rx_n, tx_n, rx_cnt, tx_cnt, rx_bad, tx_bad, rx_lat, rx_drive_cyc;
    logic [7:0] rx_cur, tx_cur;
    bit cav_low_seen;

    always @(posedge clk) cyc++;

    function automatic logic [7:0] gbyte(input logic [7:0] tag, input logic [4:0] vci, input int i);
        case (i)
            0: return tag;
            1: return 8'h00;
            2: return {7'b0, vci[4]};
            3: return {vci[3:0], 4'h0};
            default: return 8'(tag + i);
        endcase
    endfunction

    // monitors sample at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (!atm_tx_cav) cav_low_seen = 1'b1;
        if (rcv_valid) begin
            if (rcv_soc) begin
                if (rx_cnt != 0 && rx_cnt != 53) rx_bad++;
                rx_cur = rcv_data;
                if (rx_n < 16) rx_tags[rx_n] = rcv_data;
                rx_n++;
                rx_cnt = 1;
                rx_lat = cyc - rx_drive_cyc;
            end else begin
                if (rx_cnt >= 4 && rcv_data != 8'(rx_cur + rx_cnt)) rx_bad++;
                rx_cnt++;
            end
        end
        if (line_tx_valid) begin
            if (line_tx_soc) begin
                if (tx_cnt != 0 && tx_cnt != 53) tx_bad++;
                tx_cur = line_tx_data;
                if (tx_n < 16) tx_tags[tx_n] = line_tx_data;
                tx_n++;
                tx_cnt = 1;
            end else begin
                if (tx_cnt >= 4 && line_tx_data != 8'(tx_cur + tx_cnt)) tx_bad++;
                tx_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        rx_n = 0; tx_n = 0; rx_cnt = 0; tx_cnt = 0; rx_bad = 0; tx_bad = 0;
        cav_low_seen = 1'b0;
    endtask

    task automatic set_cfg(input bit en, input bit aal, input bit filt, input logic [4:0] m, input bit hide);
        @(negedge clk);
        cfg_loop_en = en; cfg_aal_mode = aal; cfg_filt_en = filt; cfg_vci_match = m; cfg_hide = hide;
        clear_mon();
    endtask

    task automatic rx_cell(input logic [7:0] tag, input logic [4:0] vci);
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            line_rx_valid = 1'b1;
            line_rx_soc   = (i == 0);
            line_rx_data  = gbyte(tag, vci, i);
            if (i == 0) rx_drive_cyc = cyc;
        end
    endtask

    task automatic rx_idle();
        @(negedge clk);
        line_rx_valid = 1'b0; line_rx_soc = 1'b0;
    endtask

    task automatic atm_cell(input logic [7:0] tag, input int stall);
        @(negedge clk);
        while (!atm_tx_cav) @(negedge clk);
        for (int i = 0; i < 53; i++) begin
            if (i > 0) @(negedge clk);
            atm_tx_valid = 1'b1;
            atm_tx_soc   = (i == 0);
            atm_tx_data  = gbyte(tag, 5'd0, i);
            if (i == 9 && stall > 0) begin
                @(negedge clk);
                atm_tx_valid = 1'b0;
                repeat (stall - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        atm_tx_valid = 1'b0; atm_tx_soc = 1'b0;
    endtask

    task automatic quiet();
        repeat (300) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(line_tx_valid == 0, "R11", "tx valid after reset", line_tx_valid, 0);
        check(rcv_valid == 0, "R11", "rcv valid after reset", rcv_valid, 0);
        check(atm_tx_cav == 1, "R11", "cav after reset", atm_tx_cav, 1);
        check(loop_ovf == 0, "R11", "ovf after reset", loop_ovf, 0);
    endtask

    task automatic t_disabled();
        set_cfg(0, 0, 0, 5'd0, 0);
        fork
            begin rx_cell(8'h10, 5'd1); rx_cell(8'h11, 5'd2); rx_idle(); end
            atm_cell(8'h20, 0);
        join
        quiet();
        check(tx_n == 1, "R2", "tx cells with loop off", tx_n, 1);
        check(tx_tags[0] == 8'h20, "R2", "tx tag with loop off", tx_tags[0], 8'h20);
        check(rx_n == 2, "R2", "rcv cells with loop off", rx_n, 2);
        check(cav_low_seen == 0, "R2", "cav dropped with loop off", cav_low_seen, 0);
    endtask

    task automatic t_atm_mode();
        set_cfg(1, 0, 1, 5'd5, 1);
        rx_cell(8'h30, 5'd3); rx_cell(8'h31, 5'd3); rx_idle();
        quiet();
        check(tx_n == 2, "R4", "looped cells in whole-port mode", tx_n, 2);
        check(tx_tags[0] == 8'h30 && tx_tags[1] == 8'h31, "R4", "looped tag order",
              {tx_tags[0], tx_tags[1]}, 16'h3031);
        check(rx_n == 2, "R4", "visible cells in whole-port mode", rx_n, 2);
        check(rx_lat == 4, "R3", "receive latency", rx_lat, 4);
        check(rx_bad == 0, "R3", "receive byte errors", rx_bad, 0);
        check(tx_bad == 0, "R1", "looped byte errors", tx_bad, 0);
    endtask

    task automatic t_aal_nofilt();
        set_cfg(1, 1, 0, 5'd5, 0);
        rx_cell(8'h40, 5'd7); rx_cell(8'h41, 5'd9); rx_idle();
        quiet();
        check(tx_n == 2, "R5", "looped cells, filter off", tx_n, 2);
        check(rx_n == 2, "R5", "visible cells, transparent", rx_n, 2);
    endtask

    task automatic t_filter();
        set_cfg(1, 1, 1, 5'd5, 1);
        rx_cell(8'h50, 5'h05); rx_cell(8'h51, 5'h06);
        rx_cell(8'h52, 5'h15); rx_cell(8'h53, 5'h05); rx_idle();
        quiet();
        check(tx_n == 2, "R6", "looped cells, filter on", tx_n, 2);
        check(tx_tags[0] == 8'h50 && tx_tags[1] == 8'h53, "R6", "matching tags looped",
              {tx_tags[0], tx_tags[1]}, 16'h5053);
        check(rx_n == 2, "R7", "visible cells, hidden mode", rx_n, 2);
        check(rx_tags[0] == 8'h51 && rx_tags[1] == 8'h52, "R7", "non-looped cells shown",
              {rx_tags[0], rx_tags[1]}, 16'h5152);
        check(tx_bad == 0 && rx_bad == 0, "R1", "byte errors with filter", tx_bad + rx_bad, 0);
    endtask

    task automatic t_cav();
        set_cfg(1, 0, 0, 5'd0, 0);
        check(atm_tx_cav == 1, "R9", "cav before loop", atm_tx_cav, 1);
        for (int i = 0; i < 53; i++) begin
            @(negedge clk);
            if (i == 5) check(atm_tx_cav == 0, "R9", "cav after decision", atm_tx_cav, 0);
            line_rx_valid = 1'b1;
            line_rx_soc   = (i == 0);
            line_rx_data  = gbyte(8'h70, 5'd0, i);
        end
        rx_idle();
        while (tx_n == 0) @(negedge clk);
        check(atm_tx_cav == 0, "R9", "cav while sending loop", atm_tx_cav, 0);
        repeat (60) @(negedge clk);
        check(atm_tx_cav == 1, "R9", "cav after loop sent", atm_tx_cav, 1);
        quiet();
    endtask

    task automatic t_overflow();
        set_cfg(1, 0, 0, 5'd0, 0);
        check(loop_ovf == 0, "R8", "ovf before overflow", loop_ovf, 0);
        fork
            atm_cell(8'h60, 400);
            begin
                repeat (20) @(negedge clk);
                for (int c = 0; c < 5; c++) rx_cell(8'(8'h61 + c), 5'd0);
                rx_idle();
            end
        join
        quiet(); quiet();
        check(tx_n == 5, "R8", "cells sent with overflow", tx_n, 5);
        check(tx_tags[0] == 8'h60, "R10", "stalled atm cell first", tx_tags[0], 8'h60);
        check(tx_tags[1] == 8'h61 && tx_tags[2] == 8'h62 && tx_tags[3] == 8'h63 && tx_tags[4] == 8'h64,
              "R10", "loop order", {tx_tags[1], tx_tags[2], tx_tags[3], tx_tags[4]}, 32'h61626364);
        check(tx_bad == 0, "R10", "tx byte errors", tx_bad, 0);
        check(loop_ovf == 1, "R8", "ovf after fifth cell", loop_ovf, 1);
        check(rx_n == 5, "R8", "forward path during overflow", rx_n, 5);
        quiet();
        check(loop_ovf == 1, "R8", "ovf stays set", loop_ovf, 1);
    endtask

    initial begin
        clear_mon();
        rx_lat = 0; rx_drive_cyc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_atm_mode();
        t_aal_nofilt();
        t_filter();
        t_cav();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule